// File: doc/BRIEF.md
# Flash command sequencer with embedded program/erase control

This block models the command interface and operation controller of a sector-erase parallel flash. It runs on a system clock. It samples the chip-enable, output-enable and write-enable strobes, the address bus and the data bus. It decodes multi-cycle unlock-and-command write sequences and starts embedded operations on a small on-block memory array. The supported operations are word program, sector erase (one or more sectors) and chip erase. Each operation lasts a number of cycles set by parameters, and each erase runs a preprogram-to-zero pass before it erases.

While an operation runs, `rdy` is low and any read returns status bits instead of array data. DQ7 is data polling and DQ6 is the toggle bit. A sector erase can be suspended so that sectors outside the erase can be read, and then resumed. The active-low reset cancels any operation. The `wr_inh` input stands in for a low-supply detector and blocks all command writes. The strobes and buses are plain pins with no handshake: the host owns bus timing, and the block never applies back-pressure.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A bus write is a run of cycles with `ce_n` and `we_n` low and `oe_n` high. The address is taken in the first cycle of the run and the data in its last cycle. The command is acted on in the cycle after the run ends.
- R2: The program sequence is four writes: AAh at unlock address 55h, 55h at AAh, A0h at 55h, then the data at the target address. When the operation completes, the word holds the AND of its old value and the written data, so bits only go from 1 to 0.
- R3: In read mode, a write whose address or data does not match the expected sequence step returns the decoder to its first step, and nothing is started.
- R4: A write of F0h at any address, in any sequence step except the program data step, returns the decoder to read mode at its first step.
- R5: Chip erase is AAh@55h, 55h@AAh, 80h@55h, AAh@55h, 55h@AAh, 10h@55h. It zeroes every word, one word per cycle, then waits ERASE_CYC cycles, then sets every word to all ones.
- R6: Sector erase uses the same five-write prefix, then 30h at any address in the chosen sector. The sector is the top SB address bits. Each further 30h write within SWIN_CYC cycles adds its sector and restarts the window. Any other write in the window, except B0h, cancels the erase with no change to the array. Unselected sectors are never changed.
- R7: B0h suspends an erase only during the preprogram or erase phase of a sector erase. While suspended, `rdy` is high and reads of unselected sectors return array data. 30h resumes the erase. B0h and 30h have no effect during a chip erase, during a program, or in read mode.
- R8: A read access during an operation returns a status word. Bit 7 is the complement of bit 7 of the final data: bit 7 of the program data for a program, and 1 for an erase. Bit 6 inverts on every new read access. All other bits are 0.
- R9: `rdy` is low from the cycle after the final command write until the operation ends. The block then returns to read mode by itself.
- R10: Asserting `rst_n` low stops any operation at once and leaves the block in read mode with `rdy` high.
- R11: While `wr_inh` is high, every completed write is ignored and the decoder state does not change.
- R12: `dout_en` is high exactly when `ce_n` and `oe_n` are low and `we_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wr_inh | input | 1 | Write inhibit; blocks command writes while high |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Read data or status word |
| dout_en | output | 1 | Read output valid (would drive the data pins) |
| rdy | output | 1 | High when ready, low while an operation runs |

## Verification
The decoder is driven with complete program, chip-erase and sector-erase sequences. It is also driven with sequences broken by a wrong address, by wrong data, and by an F0h reset in the second or the third cycle. A correct decoder starts nothing for the broken sequences, and a one-step slip shows up as an unexpected array change. A write run whose address and data change mid-cycle shows whether each is captured at the correct edge of the run. Suspend and resume are applied in read mode, during a program, during a chip erase and during a sector erase, which separates the one case that must act from the three that must not. Successive status reads, and reads from inside and outside the erased sectors, separate array data from status data.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;
  typedef enum logic [2:0] {
    ST_READ,
    ST_PROG,
    ST_SWIN,
    ST_PRE,
    ST_ERASE,
    ST_SUSP
  } op_state_t;

  localparam logic [7:0] C_UNLK1 = 8'hAA;
  localparam logic [7:0] C_UNLK2 = 8'h55;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_ERASE = 8'h80;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_SUSP  = 8'hB0;
  localparam logic [7:0] C_RESET = 8'hF0;
endpackage

// File: rtl/flash_bus_capture.sv
`timescale 1ns/1ps
module flash_bus_capture #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          cmd_v,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          rd_act,
  output logic          rd_start
);
  logic wr_act, wr_q, rd_q;
  logic [AW-1:0] addr_l;
  logic [DW-1:0] data_l;

  assign wr_act = !ce_n && !we_n && oe_n;
  assign rd_act = !ce_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      addr_l <= '0;
      data_l <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act && !wr_q) addr_l <= addr;  // first cycle of the run
      if (wr_act)          data_l <= din;   // last value before the run ends
    end
  end

  assign cmd_v    = wr_q && !wr_act;
  assign cmd_addr = addr_l;
  assign cmd_data = data_l;
  assign rd_start = rd_act && !rd_q;

  // R1: a write run produces exactly one command pulse
  p_single_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v |=> !cmd_v);
endmodule

// File: rtl/flash_array.sv
`timescale 1ns/1ps
module flash_array #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int SB = 2
) (
  input  logic              clk,
  input  logic              pg_we,
  input  logic [AW-1:0]     pg_addr,
  input  logic [DW-1:0]     pg_data,
  input  logic              zero_we,
  input  logic [AW-1:0]     zero_addr,
  input  logic              ers_we,
  input  logic [(1<<SB)-1:0] ers_mask,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam int SH    = AW - SB;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (pg_we)   mem[pg_addr]   <= mem[pg_addr] & pg_data;
    if (zero_we) mem[zero_addr] <= '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ers_we && ers_mask[SB'(i >> SH)]) mem[i] <= '1;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_op_fsm.sv
`timescale 1ns/1ps
module flash_op_fsm
  import flash_seq_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int SB        = 2,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 20,
  parameter int SWIN_CYC  = 16,
  parameter logic [AW-1:0] UA = AW'('h55),
  parameter logic [AW-1:0] UB = AW'('hAA)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_v,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [DW-1:0]     cmd_data,
  input  logic              wr_inh,
  input  logic [AW-1:0]     rd_addr,
  output logic              rdy,
  output logic              status_sel,
  output logic              exp_msb,
  output logic              pg_we,
  output logic [AW-1:0]     pg_addr,
  output logic [DW-1:0]     pg_data,
  output logic              zero_we,
  output logic [AW-1:0]     zero_addr,
  output logic              ers_we,
  output logic [(1<<SB)-1:0] ers_mask
);
  localparam int NS   = 1 << SB;
  localparam int M1   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAXC = (M1 > SWIN_CYC) ? M1 : SWIN_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  function automatic logic [SB-1:0] sect_of(input logic [AW-1:0] a);
    return a[AW-1 -: SB];
  endfunction

  op_state_t st_q, resume_q;
  logic [2:0]    seq_q;
  logic [NS-1:0] sel_q;
  logic          chip_q;
  logic [AW-1:0] pa_q, ptr_q;
  logic [DW-1:0] pd_q;
  logic [CW-1:0] cnt_q;

  logic          acc, at_ua, at_ub, susp_cmd;
  logic [7:0]    cd;
  logic [NS-1:0] cmd_hot;

  assign acc      = cmd_v && !wr_inh;
  assign cd       = cmd_data[7:0];
  assign at_ua    = cmd_addr == UA;
  assign at_ub    = cmd_addr == UB;
  assign cmd_hot  = NS'(1) << sect_of(cmd_addr);
  assign susp_cmd = acc && cd == C_SUSP && !chip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_READ;
      resume_q <= ST_PRE;
      seq_q    <= '0;
      sel_q    <= '0;
      chip_q   <= 1'b0;
      pa_q     <= '0;
      pd_q     <= '0;
      ptr_q    <= '0;
      cnt_q    <= '0;
    end else begin
      case (st_q)
        ST_READ: if (acc) begin
          if (seq_q != 3'd3 && cd == C_RESET) seq_q <= '0;
          else case (seq_q)
            3'd0: seq_q <= (at_ua && cd == C_UNLK1) ? 3'd1 : 3'd0;
            3'd1: seq_q <= (at_ub && cd == C_UNLK2) ? 3'd2 : 3'd0;
            3'd2: seq_q <= (at_ua && cd == C_PROG)  ? 3'd3 :
                           (at_ua && cd == C_ERASE) ? 3'd4 : 3'd0;
            3'd3: begin
              pa_q  <= cmd_addr;
              pd_q  <= cmd_data;
              cnt_q <= CW'(PROG_CYC - 1);
              st_q  <= ST_PROG;
              seq_q <= '0;
            end
            3'd4: seq_q <= (at_ua && cd == C_UNLK1) ? 3'd5 : 3'd0;
            3'd5: seq_q <= (at_ub && cd == C_UNLK2) ? 3'd6 : 3'd0;
            default: begin
              seq_q <= '0;
              if (at_ua && cd == C_CHIP) begin
                sel_q  <= '1;
                chip_q <= 1'b1;
                ptr_q  <= '0;
                st_q   <= ST_PRE;
              end else if (cd == C_SECT) begin
                sel_q  <= cmd_hot;
                chip_q <= 1'b0;
                cnt_q  <= CW'(SWIN_CYC - 1);
                st_q   <= ST_SWIN;
              end
            end
          endcase
        end
        ST_PROG: begin
          if (cnt_q == '0) st_q <= ST_READ;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_SWIN: begin
          if (acc && cd == C_SECT) begin
            sel_q <= sel_q | cmd_hot;
            cnt_q <= CW'(SWIN_CYC - 1);
          end else if (acc && cd != C_SUSP) begin
            sel_q <= '0;
            st_q  <= ST_READ;
          end else if (cnt_q == '0) begin
            ptr_q <= '0;
            st_q  <= ST_PRE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_PRE: begin
          if (susp_cmd) begin
            resume_q <= ST_PRE;
            st_q     <= ST_SUSP;
          end else begin
            ptr_q <= ptr_q + 1'b1;
            if (ptr_q == '1) begin
              cnt_q <= CW'(ERASE_CYC - 1);
              st_q  <= ST_ERASE;
            end
          end
        end
        ST_ERASE: begin
          if (susp_cmd) begin
            resume_q <= ST_ERASE;
            st_q     <= ST_SUSP;
          end else if (cnt_q == '0) begin
            sel_q  <= '0;
            chip_q <= 1'b0;
            st_q   <= ST_READ;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_SUSP: if (acc && cd == C_SECT) st_q <= resume_q;
        default: st_q <= ST_READ;
      endcase
    end
  end

  assign rdy        = st_q == ST_READ || st_q == ST_SUSP;
  assign status_sel = (st_q == ST_SUSP) ? sel_q[sect_of(rd_addr)] : !rdy;
  assign exp_msb    = (st_q == ST_PROG) ? pd_q[7] : 1'b1;
  assign pg_we      = st_q == ST_PROG && cnt_q == '0;
  assign pg_addr    = pa_q;
  assign pg_data    = pd_q;
  assign zero_we    = st_q == ST_PRE && !susp_cmd && sel_q[sect_of(ptr_q)];
  assign zero_addr  = ptr_q;
  assign ers_we     = st_q == ST_ERASE && cnt_q == '0 && !susp_cmd;
  assign ers_mask   = sel_q;

  // R3: the decoder only advances in read mode
  p_seq_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_READ) |-> (seq_q == '0));
  // R7: suspension never applies to a chip erase
  p_susp_sector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUSP) |-> !chip_q);
  // R6: an erase phase always has at least one sector chosen
  p_sel_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PRE || st_q == ST_ERASE) |-> (sel_q != '0));
  // R9: a finished program falls back to read mode
  p_prog_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_PROG && st_q != ST_PROG) |-> (st_q == ST_READ));
  // R11: an inhibited write leaves the decoder untouched
  p_inhibit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_v && wr_inh && st_q == ST_READ) |=> (st_q == ST_READ && $stable(seq_q)));
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int SB        = 2,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 20,
  parameter int SWIN_CYC  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          wr_inh,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          rdy
);
  localparam int NS = 1 << SB;

  logic          cmd_v, rd_start, status_sel, exp_msb, tog_q;
  logic [AW-1:0] cmd_addr, pg_addr, zero_addr;
  logic [DW-1:0] cmd_data, pg_data, rdata;
  logic          pg_we, zero_we, ers_we;
  logic [NS-1:0] ers_mask;

  flash_bus_capture #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .cmd_v(cmd_v), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rd_act(dout_en), .rd_start(rd_start));

  flash_op_fsm #(.AW(AW), .DW(DW), .SB(SB), .PROG_CYC(PROG_CYC),
                 .ERASE_CYC(ERASE_CYC), .SWIN_CYC(SWIN_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_v(cmd_v), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .wr_inh(wr_inh), .rd_addr(addr), .rdy(rdy),
    .status_sel(status_sel), .exp_msb(exp_msb), .pg_we(pg_we),
    .pg_addr(pg_addr), .pg_data(pg_data), .zero_we(zero_we),
    .zero_addr(zero_addr), .ers_we(ers_we), .ers_mask(ers_mask));

  flash_array #(.AW(AW), .DW(DW), .SB(SB)) u_mem (
    .clk(clk), .pg_we(pg_we), .pg_addr(pg_addr), .pg_data(pg_data),
    .zero_we(zero_we), .zero_addr(zero_addr), .ers_we(ers_we),
    .ers_mask(ers_mask), .rd_addr(addr), .rd_data(rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tog_q <= 1'b0;
    else if (rd_start) tog_q <= !tog_q;
  end

  always_comb begin
    dout = rdata;
    if (status_sel) begin
      dout    = '0;
      dout[7] = !exp_msb;
      dout[6] = tog_q;
    end
  end

  // R8: status words carry nothing below the toggle bit
  p_status_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && !rdy) |-> (dout[5:0] == '0));
  // R8: every new read access flips the toggle source
  p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (tog_q != $past(tog_q)));
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NV = 61;
  // vector: {kind[2:0], req[3:0], addr[7:0], data[7:0]}
  // kinds: 0 write, 1 read exact, 2 status bit7, 3 wait ready, 4 program, 5 erase prefix + last write
  localparam logic [22:0] VEC [NV] = '{
    {3'd5,4'd5,8'h55,8'h10}, // R5 chip erase
    {3'd2,4'd8,8'h00,8'h00}, // R8 erase status DQ7 = 0
    {3'd3,4'd9,8'h00,8'h00}, // R9
    {3'd1,4'd5,8'h00,8'hFF}, // R5
    {3'd1,4'd5,8'hC3,8'hFF}, // R5
    {3'd1,4'd5,8'h7F,8'hFF}, // R5
    {3'd4,4'd2,8'h10,8'h3C}, // R2 program
    {3'd2,4'd8,8'h10,8'h80}, // R8 DQ7 = ~bit7 of 3C
    {3'd3,4'd9,8'h00,8'h00}, // R9
    {3'd1,4'd2,8'h10,8'h3C}, // R2
    {3'd4,4'd2,8'h10,8'h0F}, // R2 AND with old
    {3'd3,4'd9,8'h00,8'h00}, // R9
    {3'd1,4'd2,8'h10,8'h0C}, // R2
    {3'd0,4'd3,8'h55,8'hAA}, // R3 wrong address in cycle 2
    {3'd0,4'd3,8'h55,8'h55},
    {3'd0,4'd3,8'h55,8'hA0},
    {3'd0,4'd3,8'h20,8'h00},
    {3'd1,4'd3,8'h20,8'hFF}, // R3
    {3'd0,4'd3,8'h55,8'hAA}, // R3 wrong data in cycle 2
    {3'd0,4'd3,8'hAA,8'h54},
    {3'd0,4'd3,8'h55,8'hA0},
    {3'd0,4'd3,8'h21,8'h00},
    {3'd1,4'd3,8'h21,8'hFF}, // R3
    {3'd0,4'd4,8'h55,8'hAA}, // R4 F0 as third cycle
    {3'd0,4'd4,8'hAA,8'h55},
    {3'd0,4'd4,8'h55,8'hF0},
    {3'd0,4'd4,8'h55,8'hA0},
    {3'd0,4'd4,8'h22,8'h00},
    {3'd1,4'd4,8'h22,8'hFF}, // R4
    {3'd0,4'd4,8'h55,8'hAA}, // R4 F0 as second cycle
    {3'd0,4'd4,8'h12,8'hF0},
    {3'd0,4'd4,8'hAA,8'h55},
    {3'd0,4'd4,8'h55,8'hA0},
    {3'd0,4'd4,8'h23,8'h00},
    {3'd1,4'd4,8'h23,8'hFF}, // R4
    {3'd4,4'd6,8'h40,8'h00}, // R6 setup
    {3'd3,4'd9,8'h00,8'h00},
    {3'd4,4'd6,8'h80,8'h00},
    {3'd3,4'd9,8'h00,8'h00},
    {3'd4,4'd6,8'hC1,8'h00},
    {3'd3,4'd9,8'h00,8'h00},
    {3'd5,4'd6,8'h40,8'h30}, // R6 erase sector 1
    {3'd3,4'd9,8'h00,8'h00},
    {3'd1,4'd6,8'h40,8'hFF},
    {3'd1,4'd6,8'h41,8'hFF},
    {3'd1,4'd6,8'h80,8'h00}, // R6 sector 2 untouched
    {3'd1,4'd6,8'hC1,8'h00},
    {3'd1,4'd6,8'h10,8'h0C},
    {3'd5,4'd6,8'h80,8'h30}, // R6 two sectors in one window
    {3'd0,4'd6,8'hC5,8'h30},
    {3'd3,4'd9,8'h00,8'h00},
    {3'd1,4'd6,8'h80,8'hFF},
    {3'd1,4'd6,8'hC1,8'hFF},
    {3'd1,4'd6,8'h10,8'h0C},
    {3'd0,4'd7,8'h10,8'h30}, // R7 resume in read mode ignored
    {3'd1,4'd7,8'h10,8'h0C},
    {3'd0,4'd7,8'h10,8'hB0}, // R7 suspend in read mode ignored
    {3'd1,4'd7,8'h10,8'h0C},
    {3'd5,4'd6,8'h00,8'h30}, // R6 window cancelled by other write
    {3'd0,4'd6,8'h00,8'hA0},
    {3'd1,4'd6,8'h10,8'h0C}
  };

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, we_n, wr_inh, dout_en, rdy;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  int checks = 0;
  int fails = 0;

  logic [2:0] k;
  logic [3:0] rq;
  logic [7:0] va, vd, rv, rv2;
  logic re;
  string tag;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.AW(AW), .DW(DW), .PROG_CYC(6)) u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wr_inh(wr_inh), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .rdy(rdy));

  task automatic chk(input logic ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic en);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    @(negedge clk);
    d = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prog(input logic [7:0] a, input logic [7:0] d);
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'hA0); wr(a, d);
  endtask

  task automatic ers(input logic [7:0] a, input logic [7:0] d);
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'h80);
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(a, d);
  endtask

  task automatic wait_rdy(input string what);
    int n = 0;
    while (rdy !== 1'b1 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(rdy === 1'b1, what, rdy, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    wr_inh = 1'b0; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy === 1'b1, "R9 reset rdy", rdy, 1);
    chk(dout_en === 1'b0, "R12 reset dout_en", dout_en, 0);
    // R12: write strobes alone do not enable output
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk(dout_en === 1'b0, "R12 dout_en with we_n low", dout_en, 0);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      k = VEC[i][22:20]; rq = VEC[i][19:16]; va = VEC[i][15:8]; vd = VEC[i][7:0];
      tag = $sformatf("R%0d vector %0d", rq, i);
      case (k)
        3'd0: wr(va, vd);
        3'd1: begin
          rd(va, rv, re);
          chk(re && rv === vd, tag, rv, vd);
        end
        3'd2: begin
          rd(va, rv, re);
          chk(re && rdy === 1'b0 && rv[7] === vd[7], tag, rv[7], vd[7]);
        end
        3'd3: wait_rdy(tag);
        3'd4: prog(va, vd);
        default: ers(va, vd);
      endcase
    end

    // R1: address from first cycle (55h), data from last cycle (AAh)
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 8'h55; din = 8'h00;
    @(negedge clk);
    addr = 8'h12; din = 8'hAA;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    wr(8'hAA, 8'h55); wr(8'h55, 8'hA0); wr(8'h35, 8'h00);
    chk(rdy === 1'b0, "R1 program started by split-edge write", rdy, 0);
    wait_rdy("R9 after R1 program");
    rd(8'h35, rv, re);
    chk(rv === 8'h00, "R1 captured write programmed", rv, 8'h00);

    // R11: inhibited program has no effect
    wr_inh = 1'b1;
    prog(8'h31, 8'h00);
    wr_inh = 1'b0;
    chk(rdy === 1'b1, "R11 inhibited sequence stays ready", rdy, 1);
    rd(8'h31, rv, re);
    chk(rv === 8'hFF, "R11 inhibited word unchanged", rv, 8'hFF);

    // R8: status during program, toggle on successive reads
    prog(8'h32, 8'h00);
    rd(8'h32, rv, re);
    rd(8'h32, rv2, re);
    chk(rv[7] === 1'b1 && rv[5:0] === 6'd0, "R8 program status word", rv, 8'h80);
    chk(rv[6] !== rv2[6], "R8 toggle bit changes", rv2[6], ~rv[6]);
    // R7: suspend during program ignored
    wr(8'h00, 8'hB0);
    wait_rdy("R7 program completes despite B0");
    rd(8'h32, rv, re);
    chk(rv === 8'h00, "R7 program result after ignored suspend", rv, 8'h00);

    // R7: suspend and resume a sector erase
    prog(8'h90, 8'h77); wait_rdy("R9 setup");
    prog(8'hC8, 8'h11); wait_rdy("R9 setup");
    ers(8'hC0, 8'h30);
    repeat (20) @(negedge clk);
    chk(rdy === 1'b0, "R9 sector erase busy", rdy, 0);
    wr(8'h00, 8'hB0);
    chk(rdy === 1'b1, "R7 suspended rdy high", rdy, 1);
    rd(8'h90, rv, re);
    chk(rv === 8'h77, "R7 read outside erased sector", rv, 8'h77);
    rd(8'hC8, rv, re);
    chk(rv[7] === 1'b0 && rv[5:0] === 6'd0, "R7 read inside erased sector is status", rv, 8'h00);
    repeat (50) @(negedge clk);
    chk(rdy === 1'b1, "R7 suspension holds", rdy, 1);
    wr(8'h00, 8'h30);
    chk(rdy === 1'b0, "R7 resume busy", rdy, 0);
    wait_rdy("R9 resumed erase ends");
    rd(8'hC8, rv, re);
    chk(rv === 8'hFF, "R7 erase completed after resume", rv, 8'hFF);
    rd(8'h90, rv, re);
    chk(rv === 8'h77, "R6 other sector kept", rv, 8'h77);

    // R10: hardware reset aborts a program
    prog(8'h33, 8'h00);
    chk(rdy === 1'b0, "R10 program running", rdy, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(rdy === 1'b1, "R10 ready after reset", rdy, 1);
    rd(8'h10, rv, re);
    chk(rv === 8'h0C, "R10 read mode after reset", rv, 8'h0C);
    prog(8'h34, 8'h5A);
    wait_rdy("R10 program after reset");
    rd(8'h34, rv, re);
    chk(rv === 8'h5A, "R10 program after reset result", rv, 8'h5A);

    // R7/R8: chip erase ignores suspend, status toggles
    ers(8'h55, 8'h10);
    rd(8'h10, rv, re);
    rd(8'h10, rv2, re);
    chk(rv[7] === 1'b0 && rv2[7] === 1'b0, "R8 erase DQ7 low", {rv[7], rv2[7]}, 0);
    chk(rv[6] !== rv2[6], "R8 erase toggle", rv2[6], ~rv[6]);
    wr(8'h00, 8'hB0);
    repeat (3) @(negedge clk);
    chk(rdy === 1'b0, "R7 chip erase not suspended", rdy, 0);
    wait_rdy("R9 chip erase ends");
    rd(8'h90, rv, re);
    chk(rv === 8'hFF, "R5 chip erase result", rv, 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule